// File: doc/BRIEF.md
# Cursor Pattern Memory Address Counter

This block steps through the byte addresses of a 64x64-pixel, two-bit-per-pixel cursor pattern store (1024 bytes). A processor-side register port reaches three targets. One is a low address byte. One is a configuration register, whose two least significant bits are the top two bits of the 10-bit counter. The third is a data window into the pattern memory. Software first writes the high address bits through the configuration register, then the low byte, then streams pattern bytes through the data window. Every access to the data window advances the full counter, and a carry out of the low byte moves into the configuration register.

The memory sits outside the block. The block drives its address, write enable and write data, and it captures the memory's combinational read data when the processor reads the data window. Read results are registered and appear on the processor read bus one cycle after the read strobe.

Top module: `cursor_addr_ctr`

## Requirements
- R1: After reset, `ram_addr` is 0, `ram_we` is 0, `bus_rdata` is 0, and a configuration read returns 0.
- R2: A write with `bus_sel`=1 (configuration) loads counter bits 9:8 from `bus_wdata[1:0]` and keeps counter bits 7:0.
- R3: A write with `bus_sel`=0 (low address) loads counter bits 7:0 from `bus_wdata` and keeps counter bits 9:8.
- R4: A write with `bus_sel`=2 (data) asserts `ram_we` in the same cycle, with `ram_addr` equal to the counter and `ram_wdata` equal to `bus_wdata`. The counter is one higher in the next cycle.
- R5: A read with `bus_sel`=2 returns the memory byte at the current counter on `bus_rdata` one cycle later, then advances the counter. Back-to-back reads return consecutive bytes.
- R6: A read with `bus_sel`=1 returns the written bits 7:2 of the configuration register and, in bits 1:0, the current counter bits 9:8, including any carry from earlier increments.
- R7: The counter advances from 1023 to 0.
- R8: Configuration bits 7:2 keep their written value when increments change counter bits 9:8.
- R9: A read with `bus_sel`=0 returns counter bits 7:0.
- R10: When `bus_wr` and `bus_rd` are both high, only the write takes place: `bus_rdata` keeps its value and the counter advances at most once.
- R11: Select code 3 is reserved. Writes to it change nothing and reads from it return 0. Without a strobe, the counter and `bus_rdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Target select: 0 low address, 1 configuration, 2 data, 3 reserved |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Processor write data |
| bus_rdata | output | DATA_W | Registered read result |
| ram_addr | output | ADDR_W | Pattern memory address (counter value) |
| ram_we | output | 1 | Pattern memory write enable |
| ram_wdata | output | DATA_W | Pattern memory write data |
| ram_rdata | input | DATA_W | Pattern memory combinational read data |

## Verification
The bench builds the block with the default ADDR_W=10 and DATA_W=8. At these values the whole 1024-byte pattern space is small enough to write completely and then stream back in one run. Those passes exercise every carry from the low byte into the configuration bits and the wrap from 1023 to 0. The same widths let directed cases place the counter just below a carry boundary, so the configuration read after the carry can be checked exactly.

// File: rtl/cursor_addr_ctr.sv
module cursor_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [1:0] SEL_LO  = 2'd0;
  localparam logic [1:0] SEL_CFG = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0]      ctr;
  logic [DATA_W-1:HI_W]   cfg_keep;
  logic [DATA_W-1:0]      rd_q;
  logic [DATA_W-1:0]      cfg_view;

  wire wr_lo   = bus_wr && (bus_sel == SEL_LO);
  wire wr_cfg  = bus_wr && (bus_sel == SEL_CFG);
  wire rd_go   = bus_rd && !bus_wr;
  wire dat_acc = (bus_wr || bus_rd) && (bus_sel == SEL_DAT);

  assign cfg_view  = {cfg_keep, ctr[ADDR_W-1:DATA_W]};
  assign ram_addr  = ctr;
  assign ram_we    = bus_wr && (bus_sel == SEL_DAT);
  assign ram_wdata = bus_wdata;
  assign bus_rdata = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr      <= '0;
      cfg_keep <= '0;
      rd_q     <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_keep              <= bus_wdata[DATA_W-1:HI_W];
        ctr[ADDR_W-1:DATA_W]  <= bus_wdata[HI_W-1:0];
      end
      if (wr_lo)
        ctr[DATA_W-1:0] <= bus_wdata;
      if (dat_acc)
        ctr <= ctr + STEP;
      if (rd_go) begin
        case (bus_sel)
          SEL_LO:  rd_q <= ctr[DATA_W-1:0];
          SEL_CFG: rd_q <= cfg_view;
          SEL_DAT: rd_q <= ram_rdata;
          default: rd_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cursor_addr_ctr_chk.sv
module cursor_addr_ctr_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=>
      ram_addr == {$past(bus_wdata[HI_W-1:0]), $past(ram_addr[DATA_W-1:0])});

  assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0) |=>
      ram_addr == {$past(ram_addr[ADDR_W-1:DATA_W]), $past(bus_wdata)});

  // wrap (R7) is covered by the modular step
  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_addr == $past(ram_addr) + ONE);

  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd2) |=> ram_addr == $past(ram_addr) + ONE);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |=> $stable(bus_rdata));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !(bus_rd && bus_sel == 2'd2)) |=> $stable(ram_addr));
endmodule

bind cursor_addr_ctr cursor_addr_ctr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_addr(ram_addr), .ram_we(ram_we)
);

// File: tb/cursor_addr_ctr_tb.sv
module cursor_addr_ctr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_sel = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] mem [DEPTH];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_addr_ctr #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always_ff @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + (a >> 8) * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] s, input logic w, input logic r, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic set_addr(input int a);
    acc(2'd1, 1'b1, 1'b0, DW'(a >> 8));
    acc(2'd0, 1'b1, 1'b0, DW'(a & 8'hFF));
  endtask

  task automatic t_reset;
    chk("R1 addr", ram_addr, 0);
    chk("R1 we", ram_we, 0);
    chk("R1 rdata", bus_rdata, 0);
    acc(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R1 cfg read", bus_rdata, 0);
  endtask

  task automatic t_loads;
    acc(2'd0, 1'b1, 1'b0, 8'h5A);
    chk("R3 low load", ram_addr, 10'h05A);
    acc(2'd1, 1'b1, 1'b0, 8'h02);
    chk("R2 cfg load keeps low", ram_addr, 10'h25A);
    acc(2'd0, 1'b1, 1'b0, 8'hC3);
    chk("R3 low load keeps high", ram_addr, 10'h2C3);
    acc(2'd0, 1'b0, 1'b1, 8'h00);
    chk("R9 low read", bus_rdata, 8'hC3);
  endtask

  task automatic t_write_fill;
    set_addr(10'h123);
    @(negedge clk);
    bus_sel = 2'd2; bus_wr = 1'b1; bus_wdata = 8'h5C;
    #1;
    chk("R4 we", ram_we, 1);
    chk("R4 addr", ram_addr, 10'h123);
    chk("R4 wdata", ram_wdata, 8'h5C);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 step", ram_addr, 10'h124);
    chk("R4 mem", mem[10'h123], 8'h5C);
    set_addr(0);
    for (int a = 0; a < DEPTH; a++) acc(2'd2, 1'b1, 1'b0, pat(a));
    chk("R7 wrap after fill", ram_addr, 0);
  endtask

  task automatic t_stream;
    int bad;
    bad = 0;
    set_addr(10'h3F0);
    for (int k = 0; k < 32; k++) begin
      acc(2'd2, 1'b0, 1'b1, 8'h00);
      chk("R5 stream", bus_rdata, pat((10'h3F0 + k) % DEPTH));
    end
    chk("R7 wrap after stream", ram_addr, 10'h010);
    set_addr(0);
    for (int a = 0; a < DEPTH; a++) begin
      acc(2'd2, 1'b0, 1'b1, 8'h00);
      if (bus_rdata !== pat(a)) bad++;
    end
    chk("R5 full readback mismatches", bad, 0);
  endtask

  task automatic t_carry;
    acc(2'd1, 1'b1, 1'b0, 8'hA8);
    acc(2'd0, 1'b1, 1'b0, 8'hFF);
    acc(2'd2, 1'b0, 1'b1, 8'h00);
    chk("R5 read before carry", bus_rdata, pat(10'h0FF));
    acc(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R6 carry visible", bus_rdata, 8'hA9);
    acc(2'd0, 1'b0, 1'b1, 8'h00);
    chk("R9 low after carry", bus_rdata, 8'h00);
    acc(2'd1, 1'b1, 1'b0, 8'h56);
    acc(2'd0, 1'b1, 1'b0, 8'hFF);
    acc(2'd2, 1'b1, 1'b0, pat(10'h2FF));
    acc(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R8 upper kept after carry", bus_rdata, 8'h57);
    acc(2'd2, 1'b1, 1'b0, pat(10'h300));
    for (int k = 0; k < 255; k++) acc(2'd2, 1'b0, 1'b1, 8'h00);
    chk("R7 at end", ram_addr, 10'h000);
    acc(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R8 upper kept after wrap", bus_rdata, 8'h54);
  endtask

  task automatic t_both_and_reserved;
    logic [DW-1:0] held;
    set_addr(10'h0A0);
    acc(2'd0, 1'b0, 1'b1, 8'h00);
    held = bus_rdata;
    acc(2'd2, 1'b1, 1'b1, pat(10'h0A0));
    chk("R10 rdata held", bus_rdata, held);
    chk("R10 single step", ram_addr, 10'h0A1);
    acc(2'd3, 1'b1, 1'b0, 8'hFF);
    chk("R11 reserved write addr", ram_addr, 10'h0A1);
    acc(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R11 reserved write cfg", bus_rdata, 8'h00);
    acc(2'd3, 1'b0, 1'b1, 8'h00);
    chk("R11 reserved read", bus_rdata, 0);
    repeat (5) @(negedge clk);
    chk("R11 idle addr", ram_addr, 10'h0A1);
    chk("R11 idle rdata", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loads();
    t_write_fill();
    t_stream();
    t_carry();
    t_both_and_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all-R actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule